// File: doc/BRIEF.md
# Bus Master Transfer Cycle Controller

This block runs one data transfer at a time on an asynchronous, handshaked parallel bus, after the device has already won ownership of that bus. A local requester presents a transfer type, an address and write data with a one-cycle start pulse. The controller then drives the two cycle-type lines and the address, and gates write data onto the 16 data lines. It raises master sync and waits for the slave's sync reply. For reads it strobes the returned data a fixed deskew delay after the reply.

Four transfer types are supported: word read, read-with-pause, word write and byte write. A read-modify-write is a read-with-pause followed by a word or byte write. A lock output stays high between the two cycles so that the arbitration logic keeps the bus. If no slave answers, a timeout drops master sync and reports a bus error instead of completion. Arbitration and electrical drivers sit outside this block.

Top module: `bus_xfer_master`

## Requirements
- R1: A start pulse is accepted only while busy_o is low. A start pulse seen while busy_o is high has no effect on the running cycle or on any output.
- R2: bus_c_o carries the cycle type for the whole transfer: 00 word read, 01 read-with-pause, 10 word write, 11 byte write. It is 00 while idle.
- R3: The address (bus_addr_o with bus_addr_en_o high) and bus_c_o appear in the cycle after start is accepted. msyn_o rises SETUP_CLKS (default 2) clocks later. Outside a transfer, bus_addr_o is zero.
- R4: msyn_o stays high until ssyn_i is seen (writes) or until the read strobe (reads), and is low in every other cycle.
- R5: On a word write, wdata_i drives all 16 lines. On a byte write, wdata_i[7:0] drives bits 15:8 when address bit 0 is 1, or bits 7:0 when it is 0, and the other byte is zero. bus_data_oe_o is high for the whole write cycle. On reads it is low and bus_data_o is zero.
- R6: On a read or read-with-pause, rdata_o captures bus_data_i at the DESKEW_CLKS-th (default 3) rising edge after the edge at which ssyn_i is first sampled high. Otherwise rdata_o holds its value.
- R7: After msyn_o is negated, the controller waits for ssyn_i to be sampled low. At that edge it releases the address and data lines, and done_o is high for exactly one cycle.
- R8: If ssyn_i has not been sampled high by the TMO_CLKS-th edge after msyn_o rises, msyn_o drops and the lines are released. bus_error_o is then high for exactly one cycle and done_o stays low. A reply sampled at that same edge still counts.
- R9: lock_o goes high when a read-with-pause completes. It stays high until the next transfer completes or times out, and is then cleared.
- R10: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one transfer |
| type_i | input | 2 | Transfer type (encoding in R2) |
| addr_i | input | AW | Slave address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Last strobed read data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bus_error_o | output | 1 | One-cycle timeout pulse |
| lock_o | output | 1 | Hold bus between read-with-pause and its write |
| bus_c_o | output | 2 | Cycle-type control lines |
| bus_addr_o | output | AW | Address lines |
| bus_addr_en_o | output | 1 | Address drive enable |
| bus_data_o | output | DW | Data lines, outbound |
| bus_data_oe_o | output | 1 | Data drive enable |
| bus_data_i | input | DW | Data lines, inbound |
| msyn_o | output | 1 | Master sync |
| ssyn_i | input | 1 | Slave sync |

## Verification
The slave model puts new data on the bus every cycle after its reply. A strobe that is one edge early or late therefore captures a different word from the one the model expects. Slave reply latencies of 1, 5, exactly TMO_CLKS and TMO_CLKS+1, plus a slave that never answers, separate correct acceptance from an off-by-one timeout. The byte writes use both an odd and an even address to show the lane choice. A read-with-pause is followed by a write, and in another run by a timed-out cycle, which shows both ways lock_o is cleared. A start pulse sent mid-transfer with a different type shows that busy requests are ignored.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
  typedef enum logic [1:0] {
    XF_RD  = 2'b00,
    XF_RDP = 2'b01,
    XF_WR  = 2'b10,
    XF_WRB = 2'b11
  } xfer_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_MSYN,
    ST_DESKEW,
    ST_REL
  } bxm_st_e;
endpackage

// File: rtl/bxm_delay.sv
// Counts while run_i is high; hit_o marks the N-th cycle of a run.
module bxm_delay #(
  parameter int N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  assign hit_o = run_i && (cnt_q == CW'(N - 1));
endmodule

// File: rtl/bxm_lane.sv
// Places write data on the byte lanes.
module bxm_lane #(
  parameter int DW = 16
) (
  input  logic          byte_i,
  input  logic          hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] lane_o
);
  localparam int HW = DW / 2;

  always_comb begin
    if (!byte_i)   lane_o = wdata_i;
    else if (hi_i) lane_o = {wdata_i[HW-1:0], {HW{1'b0}}};
    else           lane_o = {{HW{1'b0}}, wdata_i[HW-1:0]};
  end
endmodule

// File: rtl/bus_xfer_master.sv
module bus_xfer_master
  import bxm_pkg::*;
#(
  parameter int AW          = 18,
  parameter int DW          = 16,
  parameter int SETUP_CLKS  = 2,
  parameter int DESKEW_CLKS = 3,
  parameter int TMO_CLKS    = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    type_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          bus_error_o,
  output logic          lock_o,
  output logic [1:0]    bus_c_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_addr_en_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o,
  input  logic [DW-1:0] bus_data_i,
  output logic          msyn_o,
  input  logic          ssyn_i
);
  bxm_st_e       st_q, st_d;
  xfer_e         type_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, lane;
  logic          done_q, err_q, lock_q;
  logic          setup_hit, dsk_hit, tmo_hit;
  logic          accept, is_read, fin, tmo_fire, strobe;

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign is_read  = !type_q[1];
  assign fin      = (st_q == ST_REL) && !ssyn_i;
  assign tmo_fire = (st_q == ST_MSYN) && !ssyn_i && tmo_hit;
  assign strobe   = (st_q == ST_DESKEW) && dsk_hit;

  bxm_delay #(.N(SETUP_CLKS)) u_setup (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(st_q == ST_SETUP), .hit_o(setup_hit)
  );
  bxm_delay #(.N(DESKEW_CLKS)) u_deskew (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(st_q == ST_DESKEW), .hit_o(dsk_hit)
  );
  bxm_delay #(.N(TMO_CLKS)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(st_q == ST_MSYN), .hit_o(tmo_hit)
  );
  bxm_lane #(.DW(DW)) u_lane (
    .byte_i(type_q == XF_WRB), .hi_i(addr_q[0]), .wdata_i(wdata_q), .lane_o(lane)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_SETUP;
      ST_SETUP:  if (setup_hit) st_d = ST_MSYN;
      ST_MSYN: begin
        if (ssyn_i)       st_d = is_read ? ST_DESKEW : ST_REL;
        else if (tmo_hit) st_d = ST_IDLE;
      end
      ST_DESKEW: if (dsk_hit) st_d = ST_REL;
      ST_REL:    if (!ssyn_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      type_q  <= XF_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      err_q  <= tmo_fire;
      if (accept) begin
        type_q  <= xfer_e'(type_i);
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (strobe) rdata_q <= bus_data_i;
      if (fin)           lock_q <= (type_q == XF_RDP);
      else if (tmo_fire) lock_q <= 1'b0;
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign bus_addr_en_o = busy_o;
  assign bus_c_o       = busy_o ? type_q : 2'b00;
  assign bus_addr_o    = busy_o ? addr_q : '0;
  assign bus_data_oe_o = busy_o && type_q[1];
  assign bus_data_o    = bus_data_oe_o ? lane : '0;
  assign msyn_o        = (st_q == ST_MSYN) || (st_q == ST_DESKEW);
  assign rdata_o       = rdata_q;
  assign done_o        = done_q;
  assign bus_error_o   = err_q;
  assign lock_o        = lock_q;
endmodule

// File: rtl/bxm_checker.sv
module bxm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       bus_error_o,
  input logic [1:0] bus_c_o,
  input logic       bus_addr_en_o,
  input logic       bus_data_oe_o,
  input logic       msyn_o,
  input logic       ssyn_i
);
  // R2
  a_r2_type_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(bus_c_o));
  // R3
  a_r3_addr_before_msyn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msyn_o) |-> ($past(bus_addr_en_o) && $past(bus_addr_en_o, 2)));
  // R4
  a_r4_msyn_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msyn_o |-> (busy_o && bus_addr_en_o));
  // R5
  a_r5_oe_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> bus_c_o[1]);
  // R7
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!$past(ssyn_i) && !busy_o));
  // R8
  a_r8_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_error_o |=> !bus_error_o);
  a_r8_err_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_error_o |-> (!done_o && !msyn_o));
endmodule

bind bus_xfer_master bxm_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .bus_error_o(bus_error_o), .bus_c_o(bus_c_o), .bus_addr_en_o(bus_addr_en_o),
  .bus_data_oe_o(bus_data_oe_o), .msyn_o(msyn_o), .ssyn_i(ssyn_i)
);

// File: tb/bus_xfer_master_bench.sv
`timescale 1ns/1ps
module bus_xfer_master_bench;
  localparam int AW = 18, DW = 16, SETUP = 2, DSK = 3, TMO = 12;

  logic clk_i = 0, rst_ni = 0;
  logic start_i = 0;
  logic [1:0] type_i = 0;
  logic [AW-1:0] addr_i = 0;
  logic [DW-1:0] wdata_i = 0, bus_data_i = 0;
  logic ssyn_i = 0;
  logic [DW-1:0] rdata_o, bus_data_o;
  logic busy_o, done_o, bus_error_o, lock_o, bus_addr_en_o, bus_data_oe_o, msyn_o;
  logic [1:0] bus_c_o;
  logic [AW-1:0] bus_addr_o;

  always #10 clk_i = ~clk_i;

  bus_xfer_master #(.AW(AW), .DW(DW), .SETUP_CLKS(SETUP), .DESKEW_CLKS(DSK),
                    .TMO_CLKS(TMO)) u_bus_xfer_master (.*);

  int n_cmp = 0, n_bad = 0;

  // reference model state
  int m_ph = 0, m_t = 0, m_type = 0;
  int m_addr = 0, m_wd = 0, m_rd = 0;
  bit m_done = 0, m_err = 0, m_lock = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_t = 0; m_type = 0; m_addr = 0; m_wd = 0; m_rd = 0;
      m_done = 0; m_err = 0; m_lock = 0;
    end else begin
      m_done = 0; m_err = 0;
      case (m_ph)
        0: if (start_i) begin
             m_type = type_i; m_addr = addr_i; m_wd = wdata_i; m_ph = 1; m_t = 0;
           end
        1: begin m_t++; if (m_t == SETUP) begin m_ph = 2; m_t = 0; end end
        2: begin
             m_t++;
             if (ssyn_i) begin m_ph = (m_type < 2) ? 3 : 4; m_t = 0; end
             else if (m_t == TMO) begin m_ph = 0; m_err = 1; m_lock = 0; end
           end
        3: begin m_t++; if (m_t == DSK) begin m_rd = bus_data_i; m_ph = 4; end end
        default: if (!ssyn_i) begin m_ph = 0; m_done = 1; m_lock = (m_type == 1); end
      endcase
    end
  end

  function automatic int lane_exp();
    if (m_type != 3) return m_wd;
    return (m_addr % 2 == 1) ? ((m_wd & 'hFF) << 8) : (m_wd & 'hFF);
  endfunction

  task automatic cmp(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    automatic bit on = (m_ph != 0);
    cmp("R1 busy", busy_o, on);
    cmp("R2 bus_c", bus_c_o, on ? m_type : 0);
    cmp("R3 addr_en", bus_addr_en_o, on);
    cmp("R3 addr", bus_addr_o, on ? m_addr : 0);
    cmp("R4 msyn", msyn_o, (m_ph == 2 || m_ph == 3));
    cmp("R5 oe", bus_data_oe_o, on && m_type >= 2);
    cmp("R5 data", bus_data_o, (on && m_type >= 2) ? lane_exp() : 0);
    cmp("R6 rdata", rdata_o, m_rd);
    cmp("R7 done", done_o, m_done);
    cmp("R8 error", bus_error_o, m_err);
    cmp("R9 lock", lock_o, m_lock);
  end

  // slave model
  int s_lat = 1, s_rel = 1, s_cnt = 0, s_dcnt = 0;
  bit s_dead = 0;
  logic [DW-1:0] s_base = 16'h1000;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      ssyn_i <= 0; s_cnt = 0;
    end else if (!ssyn_i) begin
      bus_data_i <= ~s_base;
      if (msyn_o && !s_dead) begin
        s_cnt++;
        if (s_cnt >= s_lat) begin ssyn_i <= 1; s_cnt = 0; s_dcnt = 0; bus_data_i <= s_base; end
      end else s_cnt = 0;
    end else begin
      s_dcnt++;
      bus_data_i <= s_base + DW'(s_dcnt);
      if (!msyn_o) begin
        s_cnt++;
        if (s_cnt >= s_rel) begin ssyn_i <= 0; s_cnt = 0; end
      end
    end
  end

  task automatic xfer(input int t, input int a, input int d, input int lat,
                      input int rel, input bit dead, input int base);
    s_lat = lat; s_rel = rel; s_dead = dead; s_base = DW'(base);
    @(negedge clk_i);
    start_i <= 1; type_i <= 2'(t); addr_i <= AW'(a); wdata_i <= DW'(d);
    @(negedge clk_i);
    start_i <= 0;
    do @(negedge clk_i); while (m_ph != 0);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    cmp("R10 reset busy", busy_o, 0);
    cmp("R10 reset msyn", msyn_o, 0);
    cmp("R10 reset c", bus_c_o, 0);
    rst_ni <= 1;
    @(negedge clk_i);
    xfer(0, 'h00100, 0, 1, 1, 0, 'h1111);   // read, fast slave
    xfer(0, 'h02468, 0, 5, 3, 0, 'h2200);   // read, slower slave
    xfer(1, 'h00301, 0, 2, 1, 0, 'h3300);   // R9 read-with-pause
    xfer(3, 'h00301, 'hA5C3, 2, 2, 0, 0);   // R5 byte write, upper lane
    xfer(3, 'h00300, 'h5A3C, 3, 1, 0, 0);   // R5 byte write, lower lane
    xfer(2, 'h1FFFE, 'hBEEF, 4, 2, 0, 0);   // word write
    xfer(0, 'h00010, 0, TMO, 1, 0, 'h4400); // R8 reply at limit
    xfer(0, 'h00012, 0, TMO + 1, 1, 0, 'h5500); // R8 one too late
    xfer(1, 'h00020, 0, 1, 1, 0, 'h6600);   // lock set
    xfer(2, 'h00022, 'h1234, 1, 1, 1, 0);   // R8/R9 dead slave clears lock
    // R1: start during a busy cycle
    s_lat = 6; s_rel = 2; s_dead = 0; s_base = 16'h7700;
    @(negedge clk_i);
    start_i <= 1; type_i <= 2'b00; addr_i <= AW'('h00040);
    @(negedge clk_i);
    start_i <= 0;
    repeat (3) @(negedge clk_i);
    start_i <= 1; type_i <= 2'b11; addr_i <= AW'('h3FFFF); wdata_i <= 16'hFFFF;
    @(negedge clk_i);
    start_i <= 0;
    do @(negedge clk_i); while (m_ph != 0);
    repeat (3) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule